// File: doc/BRIEF.md
# Error-Rate Driven Supply Voltage Controller

This block closes a loop around a pipeline whose registers can flag late-arriving data. It counts the error events the pipeline reports over a fixed sampling window. At the end of each window it compares the count with a target count and moves a digital supply-voltage code by one step. The loop settles where the measured rate sits near the target, rather than at a fixed, conservatively margined voltage. For example, a 1.5 percent target over a 5000-cycle window is a target count of 75.

A panic input, raised when the error path itself cannot be trusted, returns the code at once to a safe level and restarts sampling. Each change of the code is announced by a one-cycle strobe to the regulator. After a change the controller holds off for a programmable number of cycles before it opens the next window, so the slow regulator is not driven into overcompensation.

Top module: `errRateVctl`

## Requirements
- R1: Sampling windows last WIN_LEN cycles (default 5000). A window counts every cycle in which `errEvt` is high, including the window's last cycle. The first window begins at the first clock edge after `rstN` rises.
- R2: At the end of a window the difference is `targetRate` minus the window's count. A difference above +1 lowers `vCode` by one.
- R3: A difference below -1 raises `vCode` by one.
- R4: A difference of -1, 0 or +1 leaves `vCode` unchanged and gives no strobe.
- R5: `vCode` never leaves the range VMIN..VMAX. A step that would cross a limit leaves the code at the limit and gives no strobe.
- R6: `vUpdate` is high for exactly one cycle, the first cycle in which `vCode` shows a new value, and is low at all other times.
- R7: After a code change the controller waits `settleCycles` cycles, during which `errEvt` is ignored, and then starts a fresh window. If `settleCycles` is 0, or the code did not change, the next window starts in the cycle after the window end.
- R8: `panic` sampled high sets `vCode` to VSAFE on that edge. It also clears the count and restarts the window, aborts any settle wait, and strobes `vUpdate` if the code differed from VSAFE. When panic arrives on the last cycle of a window, panic takes precedence over that window's evaluation.
- R9: During reset, `vCode` is VSAFE and `vUpdate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| errEvt | input | 1 | One pipeline error event in this cycle |
| panic | input | 1 | Force the safe voltage and restart sampling |
| targetRate | input | CNT_W | Target error count per window |
| settleCycles | input | SETTLE_W | Hold-off cycles after a code change |
| vCode | output | VCODE_W | Supply voltage code to the regulator |
| vUpdate | output | 1 | One-cycle strobe on every change of vCode |

## Verification
The two functions that can coincide are the end-of-window evaluation and the panic restart. The bench drives `panic` in exactly the last cycle of a window whose count would otherwise lower the code. It expects VSAFE with a strobe, not a lowered code. It then shows that the next window is a full, freshly aligned one. The bench also overlaps error events with the settle wait and checks that those events do not reach the next evaluation.

// File: rtl/errRatePkg.sv
package errRatePkg;

  typedef enum logic {
    ST_SAMPLE = 1'b0,
    ST_SETTLE = 1'b1
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntEn;      // count error events this cycle
    logic evalNow;    // last cycle of the window: judge and step
    logic forceSafe;  // panic: load safe code, clear count
  } ctlStrobe_t;

endpackage

// File: rtl/errRateCtrl.sv
module errRateCtrl
  import errRatePkg::*;
#(
  parameter int WIN_LEN  = 5000,
  parameter int SETTLE_W = 12,
  localparam int WIN_W   = $clog2(WIN_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                panic,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                willMove,
  output ctlStrobe_t          strobe
);

  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  ctlState_t             st;
  logic [WIN_W-1:0]      winCnt;
  logic [SETTLE_W-1:0]   settleCnt;
  logic                  winLast;

  assign winLast = (st == ST_SAMPLE) && (winCnt == WIN_LAST);

  always_comb begin
    strobe.forceSafe = panic;
    strobe.cntEn     = !panic && (st == ST_SAMPLE);
    strobe.evalNow   = !panic && winLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN || panic) begin
      st        <= ST_SAMPLE;
      winCnt    <= '0;
      settleCnt <= '0;
    end else begin
      case (st)
        ST_SAMPLE: begin
          if (winCnt == WIN_LAST) begin
            winCnt <= '0;
            if (willMove && (settleCycles != '0)) begin
              st        <= ST_SETTLE;
              settleCnt <= settleCycles;
            end
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleCnt <= SETTLE_W'(1)) st <= ST_SAMPLE;
          settleCnt <= settleCnt - 1'b1;
        end
        default: st <= ST_SAMPLE;
      endcase
    end
  end

  // R8
  panic_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    panic |=> (st == ST_SAMPLE && winCnt == '0));

  // R1
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_LAST);

  // R7
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SETTLE) |-> (winCnt == '0));

endmodule

// File: rtl/errRateData.sv
module errRateData
  import errRatePkg::*;
#(
  parameter int              WIN_LEN   = 5000,
  parameter int              VCODE_W   = 8,
  parameter logic [VCODE_W-1:0] VMIN   = 8'd40,
  parameter logic [VCODE_W-1:0] VMAX   = 8'd200,
  parameter logic [VCODE_W-1:0] VSAFE  = 8'd200,
  parameter int              DEAD_BAND = 1,
  localparam int             CNT_W     = $clog2(WIN_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               errEvt,
  input  logic [CNT_W-1:0]   targetRate,
  input  ctlStrobe_t         strobe,
  output logic               willMove,
  output logic [VCODE_W-1:0] vCode,
  output logic               vUpdate
);

  localparam int DW = CNT_W + 2;
  localparam logic signed [DW-1:0] BAND_HI = DW'(DEAD_BAND);
  localparam logic signed [DW-1:0] BAND_LO = -DW'(DEAD_BAND);

  logic [CNT_W-1:0]        errCnt;
  logic [CNT_W-1:0]        sampleCnt;
  logic signed [DW-1:0]    rateDiff;
  logic                    goDown;
  logic                    goUp;
  logic [VCODE_W-1:0]      nextCode;

  // final window cycle still contributes its event
  assign sampleCnt = errCnt + CNT_W'(errEvt);
  assign rateDiff  = $signed({2'b00, targetRate}) - $signed({2'b00, sampleCnt});
  assign goDown    = rateDiff > BAND_HI;
  assign goUp      = rateDiff < BAND_LO;

  always_comb begin
    nextCode = vCode;
    if (goDown && (vCode > VMIN))     nextCode = vCode - 1'b1;
    else if (goUp && (vCode < VMAX))  nextCode = vCode + 1'b1;
  end

  assign willMove = strobe.evalNow && (nextCode != vCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCode   <= VSAFE;
      vUpdate <= 1'b0;
      errCnt  <= '0;
    end else if (strobe.forceSafe) begin
      vCode   <= VSAFE;
      vUpdate <= (vCode != VSAFE);
      errCnt  <= '0;
    end else if (strobe.evalNow) begin
      vCode   <= nextCode;
      vUpdate <= willMove;
      errCnt  <= '0;
    end else begin
      vUpdate <= 1'b0;
      if (strobe.cntEn && errEvt) errCnt <= errCnt + 1'b1;
    end
  end

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vCode >= VMIN) && (vCode <= VMAX));

  // R6
  update_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    vUpdate == (vCode != $past(vCode)));

  // R8
  safe_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceSafe |=> (vCode == VSAFE));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalNow |=> (vCode == $past(vCode) || vCode == $past(vCode) + 1'b1
                        || vCode == $past(vCode) - 1'b1));

  // R4
  band_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalNow && !goUp && !goDown) |=> $stable(vCode));

endmodule

// File: rtl/errRateVctl.sv
module errRateVctl
  import errRatePkg::*;
#(
  parameter int                 WIN_LEN   = 5000,
  parameter int                 VCODE_W   = 8,
  parameter logic [VCODE_W-1:0] VMIN      = 8'd40,
  parameter logic [VCODE_W-1:0] VMAX      = 8'd200,
  parameter logic [VCODE_W-1:0] VSAFE     = 8'd200,
  parameter int                 SETTLE_W  = 12,
  parameter int                 DEAD_BAND = 1,
  localparam int                CNT_W     = $clog2(WIN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                errEvt,
  input  logic                panic,
  input  logic [CNT_W-1:0]    targetRate,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic [VCODE_W-1:0]  vCode,
  output logic                vUpdate
);

  ctlStrobe_t strobe;
  logic       willMove;

  errRateCtrl #(
    .WIN_LEN (WIN_LEN),
    .SETTLE_W(SETTLE_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .panic       (panic),
    .settleCycles(settleCycles),
    .willMove    (willMove),
    .strobe      (strobe)
  );

  errRateData #(
    .WIN_LEN  (WIN_LEN),
    .VCODE_W  (VCODE_W),
    .VMIN     (VMIN),
    .VMAX     (VMAX),
    .VSAFE    (VSAFE),
    .DEAD_BAND(DEAD_BAND)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .errEvt    (errEvt),
    .targetRate(targetRate),
    .strobe    (strobe),
    .willMove  (willMove),
    .vCode     (vCode),
    .vUpdate   (vUpdate)
  );

endmodule

// File: tb/errRateVctl_tb.sv
`timescale 1ns/1ps
module errRateVctl_tb;

  localparam int WIN  = 16;
  localparam int VW   = 4;
  localparam int SW   = 4;
  localparam int CW   = $clog2(WIN + 1);
  localparam int LO   = 2;
  localparam int HI   = 12;
  localparam int SAFE = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          errEvt = 1'b0;
  logic          panic = 1'b0;
  logic [CW-1:0] targetRate = '0;
  logic [SW-1:0] settleCycles = '0;
  logic [VW-1:0] vCode;
  logic          vUpdate;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  errRateVctl #(
    .WIN_LEN(WIN), .VCODE_W(VW), .VMIN(4'(LO)), .VMAX(4'(HI)),
    .VSAFE(4'(SAFE)), .SETTLE_W(SW), .DEAD_BAND(1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .errEvt(errEvt), .panic(panic),
    .targetRate(targetRate), .settleCycles(settleCycles),
    .vCode(vCode), .vUpdate(vUpdate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int expCode, input int expUpd);
    chk(vCode == VW'(expCode), req, vCode, expCode);
    chk(vUpdate == 1'(expUpd), req, vUpdate, expUpd);
  endtask

  // full window; n errors at its start; optional panic on its last cycle
  task automatic runWindow(input int n, input bit lastPanic);
    for (int i = 0; i < WIN; i++) begin
      errEvt = (i < n);
      panic  = lastPanic && (i == WIN - 1);
      @(negedge clk);
    end
    errEvt = 1'b0;
    panic  = 1'b0;
  endtask

  task automatic doPanic(input string req);
    int prev;
    prev  = vCode;
    panic = 1'b1;
    @(negedge clk);
    panic = 1'b0;
    checkOut(req, SAFE, (prev != SAFE) ? 1 : 0);
  endtask

  function automatic int stepRule(input int code, input int tgt, input int n);
    int d;
    d = tgt - n;
    if (d > 1 && code > LO) return code - 1;
    if (d < -1 && code < HI) return code + 1;
    return code;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int expCode;
    repeat (3) @(negedge clk);
    // R9 reset state
    checkOut("R9", SAFE, 0);
    targetRate   = CW'(WIN);
    settleCycles = SW'(3);
    rstN = 1'b1;
    // R1: first window starts at first edge after reset release
    for (int i = 0; i < WIN - 1; i++) @(negedge clk);
    checkOut("R1", SAFE, 0);
    @(negedge clk);
    checkOut("R1", SAFE - 1, 1);

    // R2 R3 R4 R5 R6 R8: exhaustive target x count sweep from the safe code
    for (int t = 0; t <= WIN; t++) begin
      for (int n = 0; n <= WIN; n++) begin
        doPanic("R8");
        targetRate = CW'(t);
        runWindow(n, 1'b0);
        expCode = stepRule(SAFE, t, n);
        checkOut((t - n > 1) ? "R2" : ((t - n < -1) ? "R5" : "R4"),
                 expCode, (expCode != SAFE) ? 1 : 0);
        @(negedge clk);
        chk(vUpdate == 1'b0, "R6", vUpdate, 0);
      end
    end

    // R5 R6: back-to-back windows with no hold-off, down to the floor
    doPanic("R8");
    settleCycles = '0;
    targetRate   = CW'(WIN);
    expCode = SAFE;
    for (int k = 0; k < HI - LO + 2; k++) begin
      runWindow(0, 1'b0);
      checkOut("R5", (expCode > LO) ? expCode - 1 : LO, (expCode > LO) ? 1 : 0);
      if (expCode > LO) expCode--;
    end
    // R3: raise from the floor
    targetRate = '0;
    runWindow(WIN, 1'b0);
    checkOut("R3", LO + 1, 1);
    runWindow(3, 1'b0);
    checkOut("R3", LO + 2, 1);
    runWindow(1, 1'b0);
    checkOut("R4", LO + 2, 0);

    // R7: errors during the hold-off are ignored
    doPanic("R8");
    settleCycles = SW'(3);
    targetRate   = CW'(WIN);
    runWindow(0, 1'b0);
    checkOut("R7", SAFE - 1, 1);
    errEvt = 1'b1;
    repeat (3) @(negedge clk);
    errEvt = 1'b0;
    targetRate = '0;
    runWindow(0, 1'b0);
    checkOut("R7", SAFE - 1, 0);
    // R7: no change -> next window immediately; 2 errors then raise
    runWindow(2, 1'b0);
    checkOut("R7", SAFE, 1);

    // R8: panic on the last cycle of a lowering window wins
    doPanic("R8");
    targetRate = CW'(WIN);
    runWindow(0, 1'b0);
    checkOut("R8", SAFE - 1, 1);
    repeat (3) @(negedge clk);
    runWindow(0, 1'b1);
    checkOut("R8", SAFE, 1);
    runWindow(0, 1'b0);
    checkOut("R8", SAFE - 1, 1);
    // R8: panic during hold-off restarts a window at once
    @(negedge clk);
    doPanic("R8");
    runWindow(0, 1'b0);
    checkOut("R8", SAFE - 1, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule